// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits beside a program counter and runs hardware loops with no branch cycles. A block loop repeats the instructions from the word after the loop command up to a given end address, for a given number of passes. A repeat loop issues the single instruction after the command a given number of times. Each cycle the sequencer sees the address being issued and returns the next fetch address. When the issued address closes a pass, the next address already points back to the body, in the same cycle. Loop state lives on a small stack, two entries by default, so one loop can be nested in another.

An interrupt controller drives a service level that stays high from acceptance until return. While it is high, loop state is frozen and no end comparison takes place. The fetch path may wander into the handler and later come back to the interrupted address, and the loop then carries on. A repeat loop pauses between repetitions in the same way.

The controller is a four-state machine. IDLE: no loop is active. BLOCK: a block loop is on top of the stack. REPEAT: a repeat loop is on top. PAUSE: an interrupt is being serviced, and the state to return to is kept in a resume register. Transitions: IDLE or BLOCK go to BLOCK on a block push and to REPEAT on a repeat push. BLOCK or REPEAT go to BLOCK or IDLE on a pop, depending on whether an entry remains. Any state goes to PAUSE while the service level is high. PAUSE goes back to the saved state in the first cycle the level is low, and that cycle can already loop back.

Top module: `zol_sequencer`

## Requirements
- R1: After reset no loop is active and the error flag is 0. With no redirect, the next address is the current address plus 1.
- R2: A block command with a nonzero count N pushes start = command address + 1 and the end address. When the end address is issued on a pass that is not the last, the next address is the start address and redirect is 1 in that same cycle.
- R3: On the last pass (the Nth issue of the end address) the entry is popped and the next address is the end address + 1, with no redirect.
- R4: A block command with count 0 pushes nothing. The next address is the end address + 1, with redirect 1.
- R5: A repeat command with count N holds the next address on the repeated instruction (command address + 1), with redirect, for N−1 issues. The Nth issue falls through to the following address.
- R6: A repeat command with count 0 pushes nothing. The next address is the command address + 2, with redirect 1.
- R7: Two loops can be nested. The inner loop runs all its passes, and the outer loop's count is unaffected until its own end address is issued.
- R8: When an inner loop ends on its last pass at an address that is also the outer loop's end address, the outer loop is judged in the same cycle. It either loops back to its own start or is popped too.
- R9: A loop command with a nonzero count while the stack is full starts nothing. It sets the error flag, which stays set until reset.
- R10: While the service level is high there is no redirect, and no count or stack level changes, even when the issued address equals an end address. The loop resumes afterwards.
- R11: Loop commands are ignored while servicing, while a repeat loop is on top, and when the issued address ends a pass of the top loop. That pass is handled as usual.
- R12: With the issue strobe low there is no redirect and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | AW | Address of the instruction being issued |
| issue_i | input | 1 | An instruction issues this cycle |
| do_cmd_i | input | 1 | The issued instruction starts a block loop |
| rep_cmd_i | input | 1 | The issued instruction starts a repeat loop |
| cnt_i | input | CW | Pass count carried by the loop command |
| end_i | input | AW | Last body address carried by a block command |
| irq_svc_i | input | 1 | High from interrupt acceptance until return |
| npc_o | output | AW | Next fetch address |
| redirect_o | output | 1 | Next address is not the sequential one |
| loop_err_o | output | 1 | Sticky stack-overflow flag |

## Verification
The end of an inner loop's last pass and the end of an outer loop can fall in the same cycle. Two block loops are nested with a shared end address, so that cycle must either loop back to the outer start or pop both entries. A repeated instruction placed on an outer loop's end address provokes the same coincidence. The second overlap is an interrupt with a loop end: the fetch address is parked on an end address while the service level is high. The cycle is judged at the ports against a bench model of the stack. The model checks the next address, the redirect bit and the error flag on every issue, and a counted-down pass that comes back too early or too late shows up as a mismatch.

// File: rtl/zol_pkg.sv
package zol_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BLOCK  = 2'd1,
        ST_REPEAT = 2'd2,
        ST_PAUSE  = 2'd3
    } zol_state_e;

endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
    parameter int DEPTH = 2,
    parameter int AW    = 16,
    parameter int CW    = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          push_rep_i,
    input  logic [AW-1:0] push_start_i,
    input  logic [AW-1:0] push_end_i,
    input  logic [CW-1:0] push_cnt_i,
    input  logic          pop1_i,
    input  logic          pop2_i,
    input  logic          dec_top_i,
    input  logic          dec_below_i,
    output logic [DW-1:0] depth_o,
    output logic [AW-1:0] top_start_o,
    output logic [AW-1:0] top_end_o,
    output logic [CW-1:0] top_cnt_o,
    output logic          top_rep_o,
    output logic [AW-1:0] bel_start_o,
    output logic [AW-1:0] bel_end_o,
    output logic [CW-1:0] bel_cnt_o
);

    logic [DW-1:0] depth_q;
    logic [AW-1:0] s_start [DEPTH];
    logic [AW-1:0] s_end   [DEPTH];
    logic [CW-1:0] s_cnt   [DEPTH];
    logic          s_rep   [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        logic [AW-1:0] e_start;
        logic [AW-1:0] e_end;
        logic [CW-1:0] e_cnt;
        logic          e_rep;
        logic          load;
        logic          dec;

        assign load = push_i && (int'(depth_q) == k);
        assign dec  = (dec_top_i && (int'(depth_q) == k + 1)) ||
                      (dec_below_i && (int'(depth_q) == k + 2));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_start <= '0;
                e_end   <= '0;
                e_cnt   <= '0;
                e_rep   <= 1'b0;
            end else if (load) begin
                e_start <= push_start_i;
                e_end   <= push_end_i;
                e_cnt   <= push_cnt_i;
                e_rep   <= push_rep_i;
            end else if (dec) begin
                e_cnt   <= e_cnt - CW'(1);
            end
        end

        assign s_start[k] = e_start;
        assign s_end[k]   = e_end;
        assign s_cnt[k]   = e_cnt;
        assign s_rep[k]   = e_rep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push_i) begin
            depth_q <= depth_q + DW'(1);
        end else if (pop2_i) begin
            depth_q <= depth_q - DW'(2);
        end else if (pop1_i) begin
            depth_q <= depth_q - DW'(1);
        end
    end

    always_comb begin
        top_start_o = '0;
        top_end_o   = '0;
        top_cnt_o   = '0;
        top_rep_o   = 1'b0;
        bel_start_o = '0;
        bel_end_o   = '0;
        bel_cnt_o   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(depth_q) == k + 1) begin
                top_start_o = s_start[k];
                top_end_o   = s_end[k];
                top_cnt_o   = s_cnt[k];
                top_rep_o   = s_rep[k];
            end
            if (int'(depth_q) == k + 2) begin
                bel_start_o = s_start[k];
                bel_end_o   = s_end[k];
                bel_cnt_o   = s_cnt[k];
            end
        end
    end

    assign depth_o = depth_q;

endmodule

// File: rtl/zol_match.sv
module zol_match #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic [AW-1:0] pc_i,
    input  logic          top_ok_i,
    input  logic          bel_ok_i,
    input  logic          top_rep_i,
    input  logic [AW-1:0] top_start_i,
    input  logic [AW-1:0] top_end_i,
    input  logic [CW-1:0] top_cnt_i,
    input  logic [AW-1:0] bel_end_i,
    input  logic [CW-1:0] bel_cnt_i,
    output logic          hit_top_o,
    output logic          last_top_o,
    output logic          hit_below_o,
    output logic          last_below_o
);

    logic [AW-1:0] top_close;

    // a repeat entry closes on its single instruction, a block on its end
    assign top_close    = top_rep_i ? top_start_i : top_end_i;
    assign hit_top_o    = top_ok_i && (pc_i == top_close);
    assign last_top_o   = (top_cnt_i <= CW'(1));
    assign hit_below_o  = bel_ok_i && (pc_i == bel_end_i);
    assign last_below_o = (bel_cnt_i <= CW'(1));

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
    import zol_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] pc_i,
    input  logic          issue_i,
    input  logic          do_cmd_i,
    input  logic          rep_cmd_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [AW-1:0] end_i,
    input  logic          irq_svc_i,
    output logic [AW-1:0] npc_o,
    output logic          redirect_o,
    output logic          loop_err_o
);

    localparam int DW = $clog2(DEPTH + 1);

    zol_state_e state_q, resume_q, run_st, post_st;
    logic          err_q;
    logic          act;
    logic          push, pop1, pop2, dec_t, dec_b, ovf_set;
    logic [DW-1:0] depth_w;
    logic [AW-1:0] top_start, top_end, bel_start, bel_end;
    logic [CW-1:0] top_cnt, bel_cnt;
    logic          top_rep;
    logic          hit_top, last_top, hit_below, last_below;

    zol_stack #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .CW    (CW)
    ) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .push_rep_i   (!do_cmd_i),
        .push_start_i (pc_i + AW'(1)),
        .push_end_i   (do_cmd_i ? end_i : pc_i + AW'(1)),
        .push_cnt_i   (cnt_i),
        .pop1_i       (pop1),
        .pop2_i       (pop2),
        .dec_top_i    (dec_t),
        .dec_below_i  (dec_b),
        .depth_o      (depth_w),
        .top_start_o  (top_start),
        .top_end_o    (top_end),
        .top_cnt_o    (top_cnt),
        .top_rep_o    (top_rep),
        .bel_start_o  (bel_start),
        .bel_end_o    (bel_end),
        .bel_cnt_o    (bel_cnt)
    );

    zol_match #(
        .AW (AW),
        .CW (CW)
    ) u_match (
        .pc_i         (pc_i),
        .top_ok_i     (depth_w != '0),
        .bel_ok_i     (int'(depth_w) >= 2),
        .top_rep_i    (top_rep),
        .top_start_i  (top_start),
        .top_end_i    (top_end),
        .top_cnt_i    (top_cnt),
        .bel_end_i    (bel_end),
        .bel_cnt_i    (bel_cnt),
        .hit_top_o    (hit_top),
        .last_top_o   (last_top),
        .hit_below_o  (hit_below),
        .last_below_o (last_below)
    );

    assign act    = issue_i && !irq_svc_i;
    assign run_st = (state_q == ST_PAUSE) ? resume_q : state_q;

    // output and stack-operation process
    always_comb begin
        npc_o      = pc_i + AW'(1);
        redirect_o = 1'b0;
        push       = 1'b0;
        pop1       = 1'b0;
        pop2       = 1'b0;
        dec_t      = 1'b0;
        dec_b      = 1'b0;
        ovf_set    = 1'b0;
        post_st    = run_st;
        if (act) begin
            unique case (run_st)
                ST_BLOCK, ST_REPEAT: begin
                    if (hit_top) begin
                        if (!last_top) begin
                            dec_t      = 1'b1;
                            redirect_o = 1'b1;
                            npc_o      = top_rep ? pc_i : top_start;
                        end else if (hit_below) begin
                            if (!last_below) begin
                                pop1       = 1'b1;
                                dec_b      = 1'b1;
                                redirect_o = 1'b1;
                                npc_o      = bel_start;
                                post_st    = ST_BLOCK;
                            end else begin
                                pop2    = 1'b1;
                                post_st = (int'(depth_w) > 2) ? ST_BLOCK : ST_IDLE;
                            end
                        end else begin
                            pop1    = 1'b1;
                            post_st = (int'(depth_w) > 1) ? ST_BLOCK : ST_IDLE;
                        end
                    end else if (run_st == ST_BLOCK && (do_cmd_i || rep_cmd_i)) begin
                        if (cnt_i == '0) begin
                            redirect_o = 1'b1;
                            npc_o      = do_cmd_i ? end_i + AW'(1) : pc_i + AW'(2);
                        end else if (int'(depth_w) == DEPTH) begin
                            ovf_set = 1'b1;
                        end else begin
                            push    = 1'b1;
                            post_st = do_cmd_i ? ST_BLOCK : ST_REPEAT;
                        end
                    end
                end
                ST_IDLE: begin
                    if (do_cmd_i || rep_cmd_i) begin
                        if (cnt_i == '0) begin
                            redirect_o = 1'b1;
                            npc_o      = do_cmd_i ? end_i + AW'(1) : pc_i + AW'(2);
                        end else begin
                            push    = 1'b1;
                            post_st = do_cmd_i ? ST_BLOCK : ST_REPEAT;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            resume_q <= ST_IDLE;
            err_q    <= 1'b0;
        end else begin
            if (irq_svc_i) begin
                state_q <= ST_PAUSE;
                if (state_q != ST_PAUSE) begin
                    resume_q <= state_q;
                end
            end else begin
                state_q <= post_st;
            end
            if (ovf_set) begin
                err_q <= 1'b1;
            end
        end
    end

    assign loop_err_o = err_q;

endmodule

// File: rtl/zol_checker.sv
module zol_checker
    import zol_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 8,
    parameter int DEPTH = 2,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pc_i,
    input logic          issue_i,
    input logic          do_cmd_i,
    input logic [CW-1:0] cnt_i,
    input logic [AW-1:0] end_i,
    input logic          irq_svc_i,
    input logic [AW-1:0] npc_o,
    input logic          redirect_o,
    input logic          loop_err_o,
    input zol_state_e    state_q,
    input logic [DW-1:0] depth_w
);

    a_r12_redirect_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> issue_i);

    a_r12_err_quiet_without_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> $stable(loop_err_o));

    a_r10_no_redirect_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq_svc_i |-> !redirect_o);

    a_r10_depth_frozen_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq_svc_i |=> $stable(depth_w));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        loop_err_o |=> loop_err_o);

    a_r7_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth_w) <= DEPTH);

    a_r4_zero_count_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && issue_i && !irq_svc_i && do_cmd_i && cnt_i == '0)
        |-> (redirect_o && npc_o == end_i + AW'(1) && pc_i != npc_o));

endmodule

bind zol_sequencer zol_checker #(
    .AW    (AW),
    .CW    (CW),
    .DEPTH (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc_i),
    .issue_i    (issue_i),
    .do_cmd_i   (do_cmd_i),
    .cnt_i      (cnt_i),
    .end_i      (end_i),
    .irq_svc_i  (irq_svc_i),
    .npc_o      (npc_o),
    .redirect_o (redirect_o),
    .loop_err_o (loop_err_o),
    .state_q    (state_q),
    .depth_w    (depth_w)
);

// File: tb/zol_sequencer_tb.sv
`timescale 1ns/1ps
module zol_sequencer_tb;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DEPTH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic          issue_i = 1'b0;
    logic          do_cmd_i = 1'b0;
    logic          rep_cmd_i = 1'b0;
    logic [CW-1:0] cnt_i = '0;
    logic [AW-1:0] end_i = '0;
    logic          irq_svc_i = 1'b0;
    logic [AW-1:0] npc_o;
    logic          redirect_o;
    logic          loop_err_o;

    always #2 clk = ~clk;

    zol_sequencer #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_i       (pc_i),
        .issue_i    (issue_i),
        .do_cmd_i   (do_cmd_i),
        .rep_cmd_i  (rep_cmd_i),
        .cnt_i      (cnt_i),
        .end_i      (end_i),
        .irq_svc_i  (irq_svc_i),
        .npc_o      (npc_o),
        .redirect_o (redirect_o),
        .loop_err_o (loop_err_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [AW-1:0] pc;

    // reference model of the loop stack
    logic [AW-1:0] m_start [DEPTH];
    logic [AW-1:0] m_end   [DEPTH];
    int            m_cnt   [DEPTH];
    bit            m_rep   [DEPTH];
    int            m_dep;
    bit            m_err;
    logic [AW-1:0] e_npc;
    bit            e_red;

    task automatic model_reset();
        m_dep = 0;
        m_err = 0;
    endtask

    task automatic model_eval();
        int t;
        bit top_rep;
        e_npc = pc_i + AW'(1);
        e_red = 0;
        if (issue_i && !irq_svc_i) begin
            t = m_dep - 1;
            top_rep = (m_dep > 0) ? m_rep[t] : 1'b0;
            if (m_dep > 0 && (top_rep ? pc_i == m_start[t] : pc_i == m_end[t])) begin
                if (m_cnt[t] > 1) begin
                    m_cnt[t]--;
                    e_red = 1;
                    e_npc = top_rep ? pc_i : m_start[t];
                end else begin
                    m_dep--;
                    if (m_dep > 0 && pc_i == m_end[m_dep-1]) begin
                        if (m_cnt[m_dep-1] > 1) begin
                            m_cnt[m_dep-1]--;
                            e_red = 1;
                            e_npc = m_start[m_dep-1];
                        end else begin
                            m_dep--;
                        end
                    end
                end
            end else if ((do_cmd_i || rep_cmd_i) && !top_rep) begin
                if (cnt_i == '0) begin
                    e_red = 1;
                    e_npc = do_cmd_i ? end_i + AW'(1) : pc_i + AW'(2);
                end else if (m_dep == DEPTH) begin
                    m_err = 1;
                end else begin
                    m_start[m_dep] = pc_i + AW'(1);
                    m_end[m_dep]   = end_i;
                    m_cnt[m_dep]   = int'(cnt_i);
                    m_rep[m_dep]   = !do_cmd_i;
                    m_dep++;
                end
            end
        end
    endtask

    task automatic step(input bit iss, input bit svc, input bit dcmd, input bit rcmd,
                        input int cnt, input logic [AW-1:0] ea, input string tag);
        bit err_before;
        @(negedge clk);
        pc_i      = pc;
        issue_i   = iss;
        irq_svc_i = svc;
        do_cmd_i  = dcmd;
        rep_cmd_i = rcmd;
        cnt_i     = CW'(cnt);
        end_i     = ea;
        #1;
        err_before = m_err;
        model_eval();
        n_cmp++;
        if (npc_o !== e_npc || redirect_o !== e_red || loop_err_o !== err_before) begin
            n_bad++;
            $display("FAIL %s pc=%h npc=%h/%h redirect=%b/%b err=%b/%b (actual/expected)",
                     tag, pc, npc_o, e_npc, redirect_o, e_red, loop_err_o, err_before);
        end
        if (iss) pc = e_npc;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, '0, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        issue_i = 0; irq_svc_i = 0; do_cmd_i = 0; rep_cmd_i = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] saved;
        int svc_left;
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R1: reset state
        pc = 16'h0010;
        step(0, 0, 0, 0, 0, '0, "R1");
        step(1, 0, 0, 0, 0, '0, "R1");

        // R2 / R3: block loop of 3 instructions, 3 passes
        pc = 16'h0100;
        step(1, 0, 1, 0, 3, 16'h0103, "R2");
        run(9, "R2 R3");
        run(2, "R3");

        // R4 / R6: zero counts
        pc = 16'h0200;
        step(1, 0, 1, 0, 0, 16'h0210, "R4");
        pc = 16'h0220;
        step(1, 0, 0, 1, 0, '0, "R6");

        // R5: repeat loop of 4
        pc = 16'h0230;
        step(1, 0, 0, 1, 4, '0, "R5");
        run(6, "R5");

        // R7: nesting with distinct ends
        pc = 16'h0300;
        step(1, 0, 1, 0, 2, 16'h0308, "R7");
        run(1, "R7");
        step(1, 0, 1, 0, 3, 16'h0304, "R7");
        run(30, "R7");

        // R8: nesting with a shared end address
        pc = 16'h0400;
        step(1, 0, 1, 0, 2, 16'h0405, "R8");
        step(1, 0, 1, 0, 2, 16'h0405, "R8");
        run(24, "R8");

        // R8: repeated instruction on the outer loop's end
        pc = 16'h0440;
        step(1, 0, 1, 0, 2, 16'h0442, "R8");
        step(1, 0, 0, 1, 3, '0, "R8");
        run(12, "R8");

        // R9: overflow on a third nested loop
        pc = 16'h0500;
        step(1, 0, 1, 0, 5, 16'h0520, "R9");
        step(1, 0, 1, 0, 5, 16'h0510, "R9");
        step(1, 0, 1, 0, 5, 16'h0504, "R9");
        run(4, "R9");
        do_reset();

        // R10 / R11: interrupt in the middle of a block loop
        pc = 16'h0600;
        step(1, 0, 1, 0, 3, 16'h0603, "R10");
        run(2, "R10");
        saved = pc;
        pc = 16'h0603;
        step(1, 1, 0, 0, 0, '0, "R10");
        pc = 16'h0603;
        step(1, 1, 1, 0, 2, 16'h0605, "R11");
        step(0, 1, 0, 0, 0, '0, "R10");
        pc = saved;
        run(12, "R10");

        // R11: command on the repeated instruction is ignored
        pc = 16'h0700;
        step(1, 0, 0, 1, 3, '0, "R11");
        step(1, 0, 1, 0, 2, 16'h0710, "R11");
        run(4, "R11");

        // R11: command on a loop end address is ignored
        pc = 16'h0720;
        step(1, 0, 1, 0, 2, 16'h0722, "R11");
        run(1, "R11");
        step(1, 0, 1, 0, 2, 16'h0730, "R11");
        run(5, "R11");

        // R10: repeat paused between repetitions
        pc = 16'h0740;
        step(1, 0, 0, 1, 3, '0, "R10");
        step(1, 0, 0, 0, 0, '0, "R10");
        step(1, 1, 0, 0, 0, '0, "R10");
        pc = 16'h0741;
        run(4, "R10");

        // R12: no issue means no effect
        pc = 16'h0760;
        step(1, 0, 1, 0, 2, 16'h0761, "R12");
        step(0, 0, 1, 0, 3, 16'h0770, "R12");
        step(0, 0, 0, 0, 0, '0, "R12");
        run(3, "R12");

        // random mix
        do_reset();
        pc = 16'h1000;
        svc_left = 0;
        for (int i = 0; i < 4000; i++) begin
            bit iss, dc, rc;
            int r, c;
            if (svc_left == 0 && ($urandom % 64) == 0) begin
                svc_left = 1 + int'($urandom % 4);
                saved = pc;
                pc = 16'hF000;
            end
            iss = ($urandom % 8) != 0;
            r = int'($urandom % 12);
            dc = (r == 0);
            rc = (r == 1);
            c = dc ? int'($urandom % 4) : int'($urandom % 5);
            if (svc_left > 0) begin
                step(iss, 1, dc, rc, c, pc + AW'(1 + $urandom % 4), "R10 R11");
                svc_left--;
                if (svc_left == 0) pc = saved;
            end else begin
                step(iss, 0, dc, rc, c, pc + AW'(1 + $urandom % 4), "R2 R5 R7 R9");
            end
            if ((i % 1000) == 999) begin
                do_reset();
                pc = 16'h1000;
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule